// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for 128 pins. The pins are grouped into four banks of 32. Software sees one word per bank for each register type. It configures pin direction, drives the output latch, arms edge detection and reads back pin levels, all through a simple single-cycle read/write port. The driven output vector is the output latch gated by the direction register. Input pins pass through a two-flop synchroniser before any edge is detected.

Edge detection applies only to pins configured as inputs, and each pin has its own enable for rising edges and for falling edges. A detected edge sets a sticky status bit, which software clears by writing 1 to it. Three level interrupts come out of the block. One follows status bit 0 of bank 0, one follows status bit 1 of bank 0, and the third is the OR of every other status bit in all banks. A one-cycle wake pulse is raised when a pin in a fixed wake-capable set, configured as an input, changes level.

The output latch is changed only through write-only set and clear words, so software can update some pins without a read-modify-write. Each bank also carries two plain storage words for alternate-function selection, which a multiplexer outside this block decodes.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register is zero: pin_out, pin_dir, bus_rdata for every mapped offset, the three interrupts and wake_req are all low.
- R2: Byte offsets, one word per bank, for banks 0,1,2,3. Level: 0x000,0x004,0x008,0x100. Direction: 0x00C,0x010,0x014,0x10C. Set: 0x018,0x01C,0x020,0x118. Clear: 0x024,0x028,0x02C,0x124. Rising enable: 0x030,0x034,0x038,0x130. Falling enable: 0x03C,0x040,0x044,0x13C. Edge status: 0x048,0x04C,0x050,0x148. Alternate-function low: 0x054,0x05C,0x064,0x06C. Alternate-function high: 0x058,0x060,0x068,0x070. Pin p of bank b is vector bit 32*b+p and bit p of that bank's word.
- R3: A level read returns, per bit, the output latch where direction is 1 and the synchronised input where direction is 0. bus_rdata is combinational on bus_addr in the same cycle.
- R4: A write to a set word ORs the data into the latch. A write to a clear word clears the latch bits where the data is 1. Other bits are not disturbed. Both words read as zero.
- R5: pin_dir equals the direction register, and pin_out equals the latch ANDed with direction, so a direction write alone changes pin_out. Register writes take effect at the clock edge that samples them.
- R6: A 0-to-1 input change present before clock edge k sets the pin's status bit after edge k+2, but only if its rising-enable bit is 1 and direction is 0. A 1-to-0 change behaves the same way with the falling-enable bit. Edges on output pins never set status.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it. If a clear and a qualifying edge on the same bit happen at the same edge, the bit stays set.
- R8: irq_pin0 equals bank 0 status bit 0. irq_pin1 equals bank 0 status bit 1. irq_other is high when any other status bit of any bank is set.
- R9: wake_req is a one-cycle pulse after edge k+2 when an input pin (direction 0) in the wake set changes level. The wake set per bank is 0x8003FE1B, 0x002001FC, 0xEC080000, 0x0012007F. Other pins, and output pins, give no pulse.
- R10: Unmapped or misaligned offsets read as zero, and writes to them change nothing.
- R11: The alternate-function words store and read back the full 32-bit written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 9 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 128 | Asynchronous pin input levels |
| pin_out | output | 128 | Driven output levels (latch AND direction) |
| pin_dir | output | 128 | Direction, 1 = output |
| irq_pin0 | output | 1 | Interrupt for bank 0 pin 0 status |
| irq_pin1 | output | 1 | Interrupt for bank 0 pin 1 status |
| irq_other | output | 1 | Interrupt for all other status bits |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The bound checker checks several properties on every cycle. The set and clear words must act on pin_out at the next edge, those words must read as zero, and an unmapped word must read as zero. An interrupt on pin 0 may rise only while that pin was an input, and it may fall only after a write-one-to-clear of its bit. The exact edge latency through the synchroniser, the edge enables, the wake set and the rule that a new edge beats a clear in the same cycle can only be shown by the bench's scenarios. The bench times stimulus against the synchroniser and compares against expected values.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int GPIO_BANKS  = 4;
  localparam int GPIO_BANK_W = 32;
  localparam int GPIO_ADDR_W = 9;
  localparam int GPIO_PIN_W  = GPIO_BANKS * GPIO_BANK_W;

  typedef enum logic [3:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_STAT, K_AFL, K_AFH
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  bank;
  } reg_dec_t;

  // Register types with three low words spaced by 4 and a fourth at +0x100.
  function automatic reg_kind_e spaced_kind(input int idx);
    case (idx)
      0:       return K_LEVEL;
      1:       return K_DIR;
      2:       return K_SET;
      3:       return K_CLR;
      4:       return K_RISE;
      5:       return K_FALL;
      default: return K_STAT;
    endcase
  endfunction

  function automatic reg_dec_t decode_addr(input logic [GPIO_ADDR_W-1:0] addr);
    reg_dec_t d;
    int       a;
    int       base;
    d.kind = K_NONE;
    d.bank = 2'd0;
    a = int'(addr);
    for (int k = 0; k < 7; k++) begin
      base = 12 * k;
      for (int b = 0; b < 3; b++) begin
        if (a == base + 4 * b) begin
          d.kind = spaced_kind(k);
          d.bank = 2'(b);
        end
      end
      if (a == 256 + base) begin
        d.kind = spaced_kind(k);
        d.bank = 2'd3;
      end
    end
    for (int b = 0; b < GPIO_BANKS; b++) begin
      if (a == 84 + 8 * b) begin
        d.kind = K_AFL;
        d.bank = 2'(b);
      end
      if (a == 88 + 8 * b) begin
        d.kind = K_AFH;
        d.bank = 2'(b);
      end
    end
    return d;
  endfunction

  function automatic logic [GPIO_BANK_W-1:0] wake_set(input int b);
    case (b)
      0:       return 32'h8003_FE1B;
      1:       return 32'h0020_01FC;
      2:       return 32'hEC08_0000;
      default: return 32'h0012_007F;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 128,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);

  logic [W-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = pin_in;
      end else begin : g_next
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign lvl = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = GPIO_BANK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_kind_e    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] edge_rise,
  input  logic [W-1:0] edge_fall,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] afl_q,
  output logic [W-1:0] afh_q
);

  logic         dir_en, latch_en, rise_en, fall_en, afl_en, afh_en;
  logic [W-1:0] latch_n, stat_n, clr_mask, new_edge;

  always_comb begin
    dir_en   = wr_en && (kind == K_DIR);
    rise_en  = wr_en && (kind == K_RISE);
    fall_en  = wr_en && (kind == K_FALL);
    afl_en   = wr_en && (kind == K_AFL);
    afh_en   = wr_en && (kind == K_AFH);
    latch_en = wr_en && ((kind == K_SET) || (kind == K_CLR));
    latch_n  = (kind == K_SET) ? (latch_q | wdata) : (latch_q & ~wdata);
    clr_mask = (wr_en && (kind == K_STAT)) ? wdata : '0;
    new_edge = ((edge_rise & rise_q) | (edge_fall & fall_q)) & ~dir_q;
    // a fresh edge overrides a same-cycle clear
    stat_n   = (stat_q & ~clr_mask) | new_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      stat_q  <= '0;
      afl_q   <= '0;
      afh_q   <= '0;
    end else begin
      if (dir_en)   dir_q   <= wdata;
      if (latch_en) latch_q <= latch_n;
      if (rise_en)  rise_q  <= wdata;
      if (fall_en)  fall_q  <= wdata;
      if (afl_en)   afl_q   <= wdata;
      if (afh_en)   afh_q   <= wdata;
      stat_q <= stat_n;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr_en,
  input  logic [GPIO_ADDR_W-1:0] bus_addr,
  input  logic [GPIO_BANK_W-1:0] bus_wdata,
  output logic [GPIO_BANK_W-1:0] bus_rdata,
  input  logic [GPIO_PIN_W-1:0]  pin_in,
  output logic [GPIO_PIN_W-1:0]  pin_out,
  output logic [GPIO_PIN_W-1:0]  pin_dir,
  output logic                   irq_pin0,
  output logic                   irq_pin1,
  output logic                   irq_other,
  output logic                   wake_req
);

  localparam int NB = GPIO_BANKS;
  localparam int BW = GPIO_BANK_W;

  reg_dec_t        dec;
  logic [NB-1:0]   bank_we;
  logic [BW-1:0]   dir_w [NB];
  logic [BW-1:0]   latch_w [NB];
  logic [BW-1:0]   rise_w [NB];
  logic [BW-1:0]   fall_w [NB];
  logic [BW-1:0]   stat_w [NB];
  logic [BW-1:0]   afl_w [NB];
  logic [BW-1:0]   afh_w [NB];
  logic [NB-1:0]   wake_hit;
  logic [GPIO_PIN_W-1:0] lvl, prev;
  logic            other_any;
  logic            wake_n;

  assign dec = decode_addr(bus_addr);

  gpio_in_sync #(.W(GPIO_PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .lvl    (lvl),
    .prev   (prev)
  );

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      logic [BW-1:0] lvl_b, prev_b;
      assign lvl_b      = lvl[b*BW +: BW];
      assign prev_b     = prev[b*BW +: BW];
      assign bank_we[b] = bus_wr_en && (dec.kind != K_NONE) && (dec.bank == 2'(b));

      gpio_bank_regs #(.W(BW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_we[b]),
        .kind      (dec.kind),
        .wdata     (bus_wdata),
        .edge_rise (lvl_b & ~prev_b),
        .edge_fall (~lvl_b & prev_b),
        .dir_q     (dir_w[b]),
        .latch_q   (latch_w[b]),
        .rise_q    (rise_w[b]),
        .fall_q    (fall_w[b]),
        .stat_q    (stat_w[b]),
        .afl_q     (afl_w[b]),
        .afh_q     (afh_w[b])
      );

      assign pin_dir[b*BW +: BW] = dir_w[b];
      assign pin_out[b*BW +: BW] = latch_w[b] & dir_w[b];
      assign wake_hit[b] = |((lvl_b ^ prev_b) & ~dir_w[b] & wake_set(b));
    end
  endgenerate

  // read path
  always_comb begin
    case (dec.kind)
      K_LEVEL: bus_rdata = (latch_w[dec.bank] & dir_w[dec.bank]) |
                           (lvl[dec.bank*BW +: BW] & ~dir_w[dec.bank]);
      K_DIR:   bus_rdata = dir_w[dec.bank];
      K_RISE:  bus_rdata = rise_w[dec.bank];
      K_FALL:  bus_rdata = fall_w[dec.bank];
      K_STAT:  bus_rdata = stat_w[dec.bank];
      K_AFL:   bus_rdata = afl_w[dec.bank];
      K_AFH:   bus_rdata = afh_w[dec.bank];
      default: bus_rdata = '0;
    endcase
  end

  // interrupt split
  always_comb begin
    other_any = |stat_w[0][BW-1:2];
    for (int i = 1; i < NB; i++) other_any = other_any | (|stat_w[i]);
  end

  assign irq_pin0  = stat_w[0][0];
  assign irq_pin1  = stat_w[0][1];
  assign irq_other = other_any;

  // wake pulse
  assign wake_n = |wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= wake_n;
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr_en,
  input logic [8:0]   bus_addr,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic [127:0] pin_out,
  input logic [127:0] pin_dir,
  input logic         irq_pin0
);

  AST_SET_ORS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 9'h018) |=>
      ((pin_out[31:0] & $past(bus_wdata)) == ($past(bus_wdata) & pin_dir[31:0]))); // R4

  AST_CLR_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 9'h024) |=>
      ((pin_out[31:0] & $past(bus_wdata)) == 32'h0)); // R4

  AST_WONLY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 9'h018 || bus_addr == 9'h124) |-> (bus_rdata == 32'h0)); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 9'h1FC || bus_addr == 9'h019) |-> (bus_rdata == 32'h0)); // R10

  AST_IRQ0_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pin0) |-> !$past(pin_dir[0])); // R6

  AST_IRQ0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pin0) |-> $past(bus_wr_en && bus_addr == 9'h048 && bus_wdata[0])); // R7

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_dir   (pin_dir),
  .irq_pin0  (irq_pin0)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;

  logic         clk;
  logic         rst_n;
  logic         bus_wr_en;
  logic [8:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in;
  logic [127:0] pin_out;
  logic [127:0] pin_dir;
  logic         irq_pin0, irq_pin1, irq_other, wake_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // sel: 0 rdata, 1 {irq_other,irq_pin1,irq_pin0}, 2 wake_req, 3 pin_out slice, 4 pin_dir slice
  typedef struct {
    int          sel;
    int          slice;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  gpio_bank_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_dir   (pin_dir),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_other (irq_other),
    .wake_req  (wake_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: compare queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.sel)
          0:       act = bus_rdata;
          1:       act = {29'h0, irq_other, irq_pin1, irq_pin0};
          2:       act = {31'h0, wake_req};
          3:       act = pin_out[it.slice*32 +: 32];
          default: act = pin_dir[it.slice*32 +: 32];
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push_chk(input int sel, input int slice, input logic [31:0] exp,
                          input string tag);
    item_t it;
    it.sel = sel; it.slice = slice; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr_en = 1'b0; bus_addr = 9'h1FC; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    push_chk(0, 0, exp, tag);
    bus_addr = 9'h1FC;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = 9'h1FC; bus_wdata = '0; pin_in = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    push_chk(1, 0, 32'h0, "R1 irqs after reset");
    push_chk(2, 0, 32'h0, "R1 wake after reset");
    push_chk(3, 0, 32'h0, "R1 pin_out after reset");
    rd_chk(9'h00C, 32'h0, "R1 direction bank0 after reset");
    rd_chk(9'h148, 32'h0, "R1 status bank3 after reset");

    // R3 R5 level mix and output gating
    pin_in[31:0] = 32'hA5A5_0000;
    wr(9'h00C, 32'h0000_FFFF);
    wr(9'h018, 32'h00F0_00FF);
    push_chk(3, 0, 32'h0000_00FF, "R5 pin_out is latch and dir");
    push_chk(4, 0, 32'h0000_FFFF, "R5 pin_dir follows direction");
    rd_chk(9'h000, 32'hA5A5_00FF, "R3 level mixes latch and input");

    // R4 clear and write-only reads
    wr(9'h024, 32'h0000_000F);
    push_chk(3, 0, 32'h0000_00F0, "R4 clear drops latch bits");
    rd_chk(9'h018, 32'h0, "R4 set word reads zero");
    rd_chk(9'h024, 32'h0, "R4 clear word reads zero");
    wr(9'h00C, 32'hFFFF_FFFF);
    push_chk(3, 0, 32'h00F0_00F0, "R5 direction alone changes pin_out");
    wr(9'h00C, 32'hFFFF_0000);
    rd_chk(9'h000, 32'h00F0_0000, "R3 level after direction swap");

    // R2 bank 3 offsets
    wr(9'h10C, 32'h0000_0001);
    wr(9'h118, 32'h0000_0003);
    push_chk(3, 3, 32'h0000_0001, "R2 bank3 set and direction");
    rd_chk(9'h100, 32'h0000_0001, "R2 bank3 level");
    rd_chk(9'h10C, 32'h0000_0001, "R2 bank3 direction readback");

    // R6 R8 R9 edges on bank 0
    wr(9'h030, 32'h0000_0003);
    wr(9'h03C, 32'h0000_0004);
    rd_chk(9'h030, 32'h0000_0003, "R2 rising enable readback");
    pin_in[0] = 1'b1;
    settle();
    push_chk(2, 0, 32'h1, "R9 wake pulse on wake pin");
    push_chk(2, 0, 32'h0, "R9 wake pulse one cycle");
    push_chk(1, 0, 32'h1, "R8 irq_pin0 after rise");
    pin_in[0] = 1'b0;
    settle();
    rd_chk(9'h048, 32'h0000_0001, "R6 fall not enabled on pin0");
    pin_in[1] = 1'b1;
    settle();
    push_chk(1, 0, 32'h3, "R8 irq_pin1 after rise");
    pin_in[2] = 1'b1;
    settle();
    rd_chk(9'h048, 32'h0000_0003, "R6 rise not enabled on pin2");
    pin_in[2] = 1'b0;
    settle();
    push_chk(1, 0, 32'h7, "R8 irq_other from pin2 fall");
    wr(9'h030, 32'h0010_0003);
    pin_in[20] = 1'b1;
    settle();
    rd_chk(9'h048, 32'h0000_0007, "R6 output pin edge ignored");

    // R7 write-one-to-clear
    wr(9'h048, 32'h0000_0002);
    push_chk(1, 0, 32'h5, "R7 clear bit1 only");
    wr(9'h048, 32'h0000_0000);
    rd_chk(9'h048, 32'h0000_0005, "R7 zero write keeps status");
    wr(9'h03C, 32'h0000_0006);
    pin_in[1] = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    wr(9'h048, 32'h0000_0002);
    rd_chk(9'h048, 32'h0000_0007, "R7 new edge beats clear");
    wr(9'h048, 32'hFFFF_FFFF);
    push_chk(1, 0, 32'h0, "R7 clear all");

    // R8 R9 other banks
    wr(9'h038, 32'h8000_0000);
    pin_in[95] = 1'b1;
    settle();
    push_chk(2, 0, 32'h1, "R9 wake on bank2 pin31");
    rd_chk(9'h050, 32'h8000_0000, "R6 bank2 status");
    push_chk(1, 0, 32'h4, "R8 irq_other from bank2");
    wr(9'h050, 32'h8000_0000);
    push_chk(1, 0, 32'h0, "R7 bank2 clear");
    pin_in[32] = 1'b1;
    settle();
    push_chk(2, 0, 32'h0, "R9 no wake outside wake set");
    pin_in[31] = 1'b0;
    settle();
    push_chk(2, 0, 32'h0, "R9 no wake for output pin");

    // R11 alternate-function words
    wr(9'h06C, 32'h1234_5678);
    wr(9'h070, 32'h9ABC_DEF0);
    rd_chk(9'h06C, 32'h1234_5678, "R11 bank3 low word");
    rd_chk(9'h070, 32'h9ABC_DEF0, "R11 bank3 high word");
    rd_chk(9'h054, 32'h0, "R11 bank0 low word untouched");

    // R10 unmapped and misaligned
    wr(9'h1FC, 32'hFFFF_FFFF);
    rd_chk(9'h1FC, 32'h0, "R10 unmapped reads zero");
    wr(9'h074, 32'hFFFF_FFFF);
    rd_chk(9'h074, 32'h0, "R10 gap offset reads zero");
    wr(9'h025, 32'hFFFF_FFFF);
    push_chk(3, 0, 32'h00F0_0000, "R10 misaligned clear ignored");
    wr(9'h00D, 32'h0);
    push_chk(4, 0, 32'hFFFF_0000, "R10 misaligned direction ignored");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule